// File: doc/BRIEF.md
# Single-Wire Bus Slot Sequencer

This block runs a single-wire open-drain bus one time slot at a time. A controller presents a slot code and pulses a start strobe. The block then pulls the line low and releases it on a fixed microsecond schedule for one of four slot kinds:

- a bus reset that ends with a presence sample;
- a write-0 slot;
- a write-1 slot;
- a read slot that samples the line a fixed time after release.

When the slot ends, a one-clock done pulse reports completion and carries the sampled bit or the presence result.

The block never drives the line high. Releasing the line means dropping the pull-low enable, and an external pull-up restores the level. The returned line level passes through a two-flop synchronizer before the sequencer looks at it.

All intervals are whole microseconds. Each microsecond is `CLK_PER_US` clocks, and a global stretch factor `DLY_MULT` multiplies it. Byte assembly, addressing commands and strong pull-up handling are left to the layer above.

Top module: `owsg_slot_gen`

## Requirements
- R1: Slot code 2 (write-1) asserts the pull-low enable for 6 us. The line is then released, and done comes 70 us after the start. The result is 0.
- R2: Slot code 1 (write-0) asserts the pull-low enable for 60 us. The line is then released, and done comes 70 us after the start. The result is 0.
- R3: Slot code 3 (read) pulls low for 6 us and samples the line 9 us after release. Done comes 55 us after the sample, 70 us after the start, and the result equals the sampled level.
- R4: Slot code 0 (reset) pulls low for 500 us and samples the line 70 us after release. Done comes `RST_RECOV_US` (default 1000) us after the sample. The result is 0 when a device held the line low and 1 otherwise.
- R5: One microsecond lasts `CLK_PER_US * DLY_MULT` clocks, so every interval is stretched by the multiplier.
- R6: The sample uses the line level captured two clock edges before the sampling edge, through two synchronizing flops.
- R7: The pull-low enable is asserted only during the initial low phase of a slot. It is never reasserted after release and is never asserted while idle.
- R8: A start strobe while busy is ignored. The running slot keeps its code and timing, and no extra slot follows.
- R9: Done is high for exactly one clock, in the same cycle that busy falls, with the result valid in that cycle.
- R10: After reset the pull-low enable, busy, done and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| cmd_i | input | 2 | Slot code: 0 reset, 1 write-0, 2 write-1, 3 read |
| line_i | input | 1 | Observed bus level (asynchronous) |
| pull_low_o | output | 1 | Open-drain pull-low enable |
| busy_o | output | 1 | Slot in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | 1 | Read bit or presence flag (0 = present) |

## Verification
Counting from the edge that accepts start as cycle 0, the pull-low enable is high for cycles 1 through L·T, where L is the low time in microseconds and T is clocks per microsecond. Done appears in cycle S·T+1, where S is the whole slot length in microseconds. The sampled level is the one the line held at edge (L+W)·T−2, where W is the release-to-sample time. The bench counts cycles from the accepting edge and samples at falling edges. It compares the exact high count, the done cycle and the result against these formulas. Line flips placed one cycle either side of the synchronizer boundary pin down the capture edge.

// File: rtl/owsg_pkg.sv
package owsg_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'd0,
        CMD_WR0   = 2'd1,
        CMD_WR1   = 2'd2,
        CMD_READ  = 2'd3
    } slot_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_TAIL = 2'd3
    } slot_phase_e;

endpackage

// File: rtl/owsg_line_sync.sv
module owsg_line_sync #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = line_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: RST_LEVEL, s2: RST_LEVEL};
        end else begin
            q <= d;
        end
    end

    assign line_o = q.s2;

endmodule

// File: rtl/owsg_us_tick.sv
module owsg_us_tick #(
    parameter int TPU = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int PW = (TPU > 1) ? $clog2(TPU) : 1;
    localparam logic [PW-1:0] LAST = PW'(TPU - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = !clr_i && (cnt_q == LAST);

    generate
        if (TPU > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R5
        end
    endgenerate

endmodule

// File: rtl/owsg_slot_times.sv
module owsg_slot_times
    import owsg_pkg::*;
#(
    parameter int CNT_W        = 11,
    parameter int WR1_LOW_US   = 6,
    parameter int WR1_REL_US   = 64,
    parameter int WR0_LOW_US   = 60,
    parameter int WR0_REL_US   = 10,
    parameter int RD_LOW_US    = 6,
    parameter int RD_SAMP_US   = 9,
    parameter int RD_TAIL_US   = 55,
    parameter int RST_LOW_US   = 500,
    parameter int RST_SAMP_US  = 70,
    parameter int RST_RECOV_US = 1000
) (
    input  slot_cmd_e        cmd_i,
    output logic [CNT_W-1:0] low_us_o,
    output logic [CNT_W-1:0] wait_us_o,
    output logic [CNT_W-1:0] tail_us_o,
    output logic             sample_o
);

    always_comb begin
        unique case (cmd_i)
            CMD_RESET: begin
                low_us_o  = CNT_W'(RST_LOW_US);
                wait_us_o = CNT_W'(RST_SAMP_US);
                tail_us_o = CNT_W'(RST_RECOV_US);
                sample_o  = 1'b1;
            end
            CMD_WR0: begin
                low_us_o  = CNT_W'(WR0_LOW_US);
                wait_us_o = CNT_W'(WR0_REL_US);
                tail_us_o = '0;
                sample_o  = 1'b0;
            end
            CMD_WR1: begin
                low_us_o  = CNT_W'(WR1_LOW_US);
                wait_us_o = CNT_W'(WR1_REL_US);
                tail_us_o = '0;
                sample_o  = 1'b0;
            end
            default: begin
                low_us_o  = CNT_W'(RD_LOW_US);
                wait_us_o = CNT_W'(RD_SAMP_US);
                tail_us_o = CNT_W'(RD_TAIL_US);
                sample_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/owsg_slot_gen.sv
module owsg_slot_gen
    import owsg_pkg::*;
#(
    parameter int CLK_PER_US   = 8,
    parameter int DLY_MULT     = 1,
    parameter int RST_RECOV_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] cmd_i,
    input  logic       line_i,
    output logic       pull_low_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       result_o
);

    localparam int TPU    = CLK_PER_US * DLY_MULT;
    localparam int MAX_US = (RST_RECOV_US > 500) ? RST_RECOV_US : 500;
    localparam int CNT_W  = $clog2(MAX_US + 1);

    typedef struct packed {
        slot_phase_e      ph;
        slot_cmd_e        cmd;
        logic [CNT_W-1:0] cnt;
        logic             pull;
        logic             busy;
        logic             done;
        logic             res;
    } st_t;

    st_t d, q;

    logic             line_s;
    logic             tick;
    logic [CNT_W-1:0] low_us, wait_us, tail_us;
    logic             samp_en;

    owsg_line_sync #(.RST_LEVEL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_o (line_s)
    );

    owsg_us_tick #(.TPU(TPU)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!q.busy),
        .tick_o (tick)
    );

    owsg_slot_times #(
        .CNT_W        (CNT_W),
        .RST_RECOV_US (RST_RECOV_US)
    ) u_times (
        .cmd_i     (q.cmd),
        .low_us_o  (low_us),
        .wait_us_o (wait_us),
        .tail_us_o (tail_us),
        .sample_o  (samp_en)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph   = PH_LOW;
                    d.cmd  = slot_cmd_e'(cmd_i);
                    d.cnt  = '0;
                    d.pull = 1'b1;
                    d.busy = 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (q.cnt == low_us - CNT_W'(1)) begin
                        d.ph   = PH_WAIT;
                        d.cnt  = '0;
                        d.pull = 1'b0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_WAIT: begin
                if (tick) begin
                    if (q.cnt == wait_us - CNT_W'(1)) begin
                        d.cnt = '0;
                        d.res = samp_en ? line_s : 1'b0;
                        if (tail_us == '0) begin
                            d.ph   = PH_IDLE;
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end else begin
                            d.ph = PH_TAIL;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == tail_us - CNT_W'(1)) begin
                        d.ph   = PH_IDLE;
                        d.cnt  = '0;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, cmd: CMD_RESET, cnt: '0, pull: 1'b0,
                   busy: 1'b0, done: 1'b0, res: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pull_low_o = q.pull;
    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign result_o   = q.res;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pull_low_o); // R7
    AST_NO_PULL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_WAIT || q.ph == PH_TAIL) |-> !pull_low_o); // R7
    AST_SLOT_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> pull_low_o); // R1
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (q.cmd == $past(q.cmd)) && (busy_o || done_o)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R9

endmodule

// File: tb/sim_owsg_slot_gen.sv
module sim_owsg_slot_gen;

    localparam int CPU   = 1;
    localparam int MULT  = 2;
    localparam int RECOV = 1000;
    localparam int T     = CPU * MULT;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        dev;
        logic [11:0] low_us;
        logic [11:0] tot_us;
        logic        res;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 1'b1, 12'd6,   12'd70,   1'b0, 4'd1},  // R1 write-1, idle line
        '{2'd2, 1'b0, 12'd6,   12'd70,   1'b0, 4'd1},  // R1 write-1, line held low
        '{2'd1, 1'b1, 12'd60,  12'd70,   1'b0, 4'd2},  // R2 write-0
        '{2'd3, 1'b1, 12'd6,   12'd70,   1'b1, 4'd3},  // R3 read one
        '{2'd3, 1'b0, 12'd6,   12'd70,   1'b0, 4'd3},  // R3 read zero
        '{2'd0, 1'b0, 12'd500, 12'd1570, 1'b0, 4'd4},  // R4 presence
        '{2'd0, 1'b1, 12'd500, 12'd1570, 1'b1, 4'd4},  // R4 no device
        '{2'd1, 1'b0, 12'd60,  12'd70,   1'b0, 4'd2}   // R2 write-0, line low
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] cmd_i = 2'd0;
    logic       dev = 1'b1;
    logic       line_i;
    logic       pull_low_o, busy_o, done_o, result_o;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    assign line_i = pull_low_o ? 1'b0 : dev;

    owsg_slot_gen #(.CLK_PER_US(CPU), .DLY_MULT(MULT), .RST_RECOV_US(RECOV)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmd_i      (cmd_i),
        .line_i     (line_i),
        .pull_low_o (pull_low_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Runs one slot. dev takes dev_a, then dev_b from falling edge flip_at on.
    // mid_c > 0 injects a start strobe with the other write code at that cycle.
    task automatic run_slot(input logic [1:0] cmd, input logic dev_a, input logic dev_b,
                            input int flip_at, input int low_us, input int tot_us,
                            input logic exp_res, input string req, input int mid_c);
        int  c = 0;
        int  highs = 0;
        int  done_c = 0;
        bit  rehigh = 0;
        bit  released = 0;
        bit  busy_gap = 0;
        @(negedge clk);
        dev = dev_a;
        cmd_i = cmd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c = 1;
        while (done_c == 0 && c < 8000) begin
            if (c >= flip_at) dev = dev_b;
            if (c == mid_c) begin
                start_i = 1'b1;
                cmd_i = (cmd == 2'd1) ? 2'd2 : 2'd1;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin
                done_c = c;
                chk(req, "result at done", result_o, exp_res);
                chk("R9", "busy low with done", busy_o, 0);
            end else begin
                if (!busy_o) busy_gap = 1;
                if (pull_low_o) begin
                    highs++;
                    if (released) rehigh = 1;
                end else begin
                    released = 1;
                end
                @(negedge clk);
                c++;
            end
        end
        start_i = 1'b0;
        chk("R5", "pull-low clocks", highs, low_us * T);
        chk(req, "done cycle", done_c, tot_us * T + 1);
        chk("R7", "reassert after release", int'(rehigh), 0);
        chk(req, "busy held through slot", int'(busy_gap), 0);
        @(negedge clk);
        chk("R9", "done width", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "pull_low in reset", pull_low_o, 0);
        chk("R10", "busy in reset", busy_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "pull_low after reset", pull_low_o, 0);
        chk("R10", "busy after reset", busy_o, 0);
        chk("R10", "done after reset", done_o, 0);
        chk("R10", "result after reset", result_o, 0);

        for (int i = 0; i < NV; i++) begin
            run_slot(VEC[i].cmd, VEC[i].dev, VEC[i].dev, 0,
                     int'(VEC[i].low_us), int'(VEC[i].tot_us), VEC[i].res,
                     $sformatf("R%0d", VEC[i].req), 0);
        end

        // R6: sample edge is (6+9)*T; level seen there is from falling edge s-2
        run_slot(2'd3, 1'b0, 1'b1, 15 * T - 1, 6, 70, 1'b0, "R6", 0);
        run_slot(2'd3, 1'b1, 1'b0, 15 * T - 2, 6, 70, 1'b0, "R6", 0);

        // R8: start while busy, inside low phase and inside release phase
        run_slot(2'd1, 1'b1, 1'b1, 0, 60, 70, 1'b0, "R8", 20);
        for (int k = 0; k < 4; k++) begin
            chk("R8", "no extra slot busy", busy_o, 0);
            chk("R8", "no extra slot pull", pull_low_o, 0);
            @(negedge clk);
        end
        run_slot(2'd3, 1'b1, 1'b1, 0, 6, 70, 1'b1, "R8", 40);
        for (int k = 0; k < 4; k++) begin
            chk("R8", "no extra slot busy", busy_o, 0);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule